// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This unit watches the SDA and SCL lines of an I2C bus from the system clock domain. It recognises START and STOP conditions and keeps a bus-busy flag from them. After every START it collects the first byte, compares that byte with a programmable own address, and pulls SDA low on the ninth clock when the byte matches. On an address match with a write direction it keeps receiving data bytes and answers each one with ACK or NACK, as a control bit selects. The unit never drives SDA high. It only asserts an output-enable that pulls the open-drain line low.

A register port with one select bit gives access to two registers. The first is the own-address register. The second is a control register that holds the enable, the extended-match mode and the acknowledge policy, and it also shows the busy flag. When the unit reports an address match, it also reports the direction bit that arrived with the address.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the address register reads 0xA0, the control register reads 0x00, and sda_oe, bus_busy, addr_hit and rw_bit are all 0.
- R2: While the unit is enabled, SDA falling with SCL high (START) sets bus_busy, and SDA rising with SCL high (STOP) clears it. Each line passes two synchroniser flops, so the flag changes on the third clock edge after the line changes.
- R3: With extended mode off, an address byte whose bits [7:1] equal address register bits [7:1] is acknowledged. sda_oe rises after the SCL falling edge that ends the 8th bit and falls after the SCL falling edge that ends the 9th bit.
- R4: An address byte that does not match gets no acknowledge. addr_hit stays 0, and every byte that follows is ignored until the next START.
- R5: With extended mode on, an address byte is acknowledged when its bits [7:4] equal address register bits [7:4], or when the whole byte is 0x00 (general call).
- R6: On a match, addr_hit is set and rw_bit takes bit 0 of the address byte. A START or a STOP clears both.
- R7: After a write-direction match, each later data byte is acknowledged on its 9th clock when control bit 1 is 0 and is left unacknowledged when it is 1. After a read-direction match, no later byte is acknowledged.
- R8: Writing control bit 7 to 0 releases sda_oe and clears bus_busy, addr_hit and rw_bit on the next clock. The address register and control bits 1 and 0 keep their values.
- R9: A START that arrives in the middle of a byte drops the partial byte and restarts address reception.
- R10: With reg_sel 0 the port writes and reads the 8-bit address register. With reg_sel 1 it writes control bits 7 (enable), 1 (NACK data) and 0 (extended mode), and it reads those bits together with bus_busy at bit 2. Other bits read 0. Writes take effect on the next clock.
- R11: While the unit is disabled, bus activity leaves bus_busy and sda_oe at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the address register, 1 selects control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| bus_busy | output | 1 | A START has been seen and no STOP has followed |
| addr_hit | output | 1 | The current address byte matched |
| rw_bit | output | 1 | Direction bit of the matched address |

## Verification
A change on either bus line shows up at the unit's outputs three clock edges later: two edges to cross the synchroniser and one to update state. sda_oe therefore moves three edges after the SCL falling edge that triggers it, while register writes land one edge after the strobe. The bench's behavioural model keeps a four-deep history of the sampled lines and judges each event from the sample taken two edges earlier, so its expected outputs carry the same delay. Every output is compared on every falling clock edge. The scenario checks sample the acknowledge in the middle of the SCL high phase of the 9th bit, well clear of any transition.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter logic [7:0] OWN_RST = 8'hA0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       bus_busy,
  output logic       addr_hit,
  output logic       rw_bit
);
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA, PH_SKIP} phase_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic [7:0] own_addr;
  logic       en, nack_data, ext_mode;
  phase_t     phase;
  logic [3:0] cnt;
  logic [7:0] sr;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire start_ev = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire in_byte  = (phase == PH_ADDR) || (phase == PH_DATA);

  wire match = ext_mode ? ((sr[7:4] == own_addr[7:4]) || (sr == 8'h00))
                        : (sr[7:1] == own_addr[7:1]);

  assign reg_rdata = reg_sel ? {en, 4'b0000, bus_busy, nack_data, ext_mode} : own_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_addr  <= OWN_RST;
      en        <= 1'b0;
      nack_data <= 1'b0;
      ext_mode  <= 1'b0;
    end else if (reg_we) begin
      if (!reg_sel) own_addr <= reg_wdata;
      else {en, nack_data, ext_mode} <= {reg_wdata[7], reg_wdata[1], reg_wdata[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      sr       <= '0;
      sda_oe   <= 1'b0;
      bus_busy <= 1'b0;
      addr_hit <= 1'b0;
      rw_bit   <= 1'b0;
    end else if (!en) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      sr       <= '0;
      sda_oe   <= 1'b0;
      bus_busy <= 1'b0;
      addr_hit <= 1'b0;
      rw_bit   <= 1'b0;
    end else if (start_ev) begin
      phase    <= PH_ADDR;
      cnt      <= '0;
      sda_oe   <= 1'b0;
      bus_busy <= 1'b1;
      addr_hit <= 1'b0;
      rw_bit   <= 1'b0;
    end else if (stop_ev) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      sda_oe   <= 1'b0;
      bus_busy <= 1'b0;
      addr_hit <= 1'b0;
      rw_bit   <= 1'b0;
    end else if (scl_rise && in_byte && cnt != 4'd9) begin
      if (cnt < 4'd8) sr <= {sr[6:0], sda_s};
      cnt <= cnt + 4'd1;
    end else if (scl_fall && in_byte) begin
      if (cnt == 4'd8) begin
        if (phase == PH_DATA) begin
          sda_oe <= ~nack_data;
        end else if (match) begin
          sda_oe   <= 1'b1;
          addr_hit <= 1'b1;
          rw_bit   <= sr[0];
        end else begin
          phase <= PH_SKIP;
          cnt   <= '0;
        end
      end else if (cnt == 4'd9) begin
        sda_oe <= 1'b0;
        cnt    <= '0;
        if (phase == PH_ADDR) phase <= rw_bit ? PH_SKIP : PH_DATA;
      end
    end
  end
endmodule

module i2c_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_oe,
  input logic bus_busy,
  input logic addr_hit,
  input logic rw_bit
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_ev) |=> bus_busy); // R2
  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop_ev && !start_ev) |=> (!bus_busy && !sda_oe)); // R2
  AST_ACK_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> bus_busy); // R3
  AST_HIT_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> bus_busy); // R6
  AST_RW_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rw_bit |-> addr_hit); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_oe && !bus_busy && !addr_hit && !rw_bit)); // R8
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .start_ev(start_ev), .stop_ev(stop_ev),
  .sda_oe(sda_oe), .bus_busy(bus_busy), .addr_hit(addr_hit), .rw_bit(rw_bit)
);

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic sda_oe, bus_busy, addr_hit, rw_bit;
  logic [7:0] reg_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  wire sda_line = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2c_addr_match i_i2c_addr_match (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_busy(bus_busy), .addr_hit(addr_hit), .rw_bit(rw_bit));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: lines are judged two samples late, as the requirements state.
  bit hs_scl[$], hs_sda[$];
  int e_addr = 8'hA0, e_en = 0, e_nack = 0, e_ext = 0;
  int e_busy = 0, e_hit = 0, e_rw = 0, e_oe = 0;
  int mode = 0, bits = 0, shifted = 0;  // mode: 0 idle, 1 address, 2 data, 3 skip

  always @(posedge clk) begin
    bit c, d, pc, pd;
    int old_en, ok;
    if (!rst_n) begin
      hs_scl = {1, 1, 1, 1};
      hs_sda = {1, 1, 1, 1};
    end else begin
      hs_scl.push_front(m_scl); hs_sda.push_front(sda_line);
      void'(hs_scl.pop_back()); void'(hs_sda.pop_back());
      c = hs_scl[2]; d = hs_sda[2]; pc = hs_scl[3]; pd = hs_sda[3];
      old_en = e_en;
      if (!old_en) begin
        mode = 0; bits = 0; shifted = 0; e_busy = 0; e_hit = 0; e_rw = 0; e_oe = 0;
      end else if (c && pc && pd && !d) begin
        mode = 1; bits = 0; e_busy = 1; e_hit = 0; e_rw = 0; e_oe = 0;
      end else if (c && pc && !pd && d) begin
        mode = 0; bits = 0; e_busy = 0; e_hit = 0; e_rw = 0; e_oe = 0;
      end else if (c && !pc && (mode == 1 || mode == 2) && bits < 9) begin
        if (bits < 8) shifted = ((shifted << 1) | d) & 8'hFF;
        bits++;
      end else if (!c && pc && (mode == 1 || mode == 2)) begin
        if (bits == 8) begin
          if (mode == 2) e_oe = !e_nack;
          else begin
            if (e_ext) ok = ((shifted >> 4) == (e_addr >> 4)) || (shifted == 0);
            else ok = ((shifted >> 1) == (e_addr >> 1));
            if (ok) begin e_oe = 1; e_hit = 1; e_rw = shifted & 1; end
            else begin mode = 3; bits = 0; end
          end
        end else if (bits == 9) begin
          e_oe = 0; bits = 0;
          if (mode == 1) mode = e_rw ? 3 : 2;
        end
      end
      if (reg_we) begin
        if (!reg_sel) e_addr = reg_wdata;
        else begin e_en = reg_wdata[7]; e_nack = reg_wdata[1]; e_ext = reg_wdata[0]; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 busy", bus_busy, e_busy);
      chk("R3 sda_oe", sda_oe, e_oe);
      chk("R6 addr_hit", addr_hit, e_hit);
      chk("R6 rw_bit", rw_bit, e_rw);
      chk("R10 rdata", reg_rdata,
          reg_sel ? ((e_en << 7) | (e_busy << 2) | (e_nack << 1) | e_ext) : e_addr);
    end
  end

  task automatic wt(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(bit sel, logic [7:0] v);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic do_start; m_sda = 1; wt(6); m_scl = 1; wt(6); m_sda = 0; wt(6); m_scl = 0; wt(6); endtask
  task automatic do_stop; m_sda = 0; wt(6); m_scl = 1; wt(6); m_sda = 1; wt(6); endtask
  task automatic send_bit(bit b); m_sda = b; wt(6); m_scl = 1; wt(6); m_scl = 0; wt(6); endtask
  task automatic send_byte(logic [7:0] v, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    m_sda = 1; wt(6); m_scl = 1; wt(3); acked = sda_oe; wt(3); m_scl = 0; wt(6);
  endtask

  initial begin
    bit a;
    wt(3); rst_n = 1; wt(1);
    reg_sel = 0; wt(1); chk("R1 addr reset", reg_rdata, 8'hA0);
    reg_sel = 1; wt(1); chk("R1 ctrl reset", reg_rdata, 8'h00);
    chk("R1 outputs", {sda_oe, bus_busy, addr_hit, rw_bit}, 0);

    do_start; chk("R11 busy while disabled", bus_busy, 0);
    send_byte(8'hA0, a); chk("R11 no ack while disabled", a, 0); do_stop;

    wr(1, 8'h80);
    do_start; chk("R2 busy after start", bus_busy, 1);
    send_byte(8'hA0, a); chk("R3 address ack", a, 1); chk("R6 hit", addr_hit, 1);
    chk("R6 rw write", rw_bit, 0);
    send_byte(8'h5A, a); chk("R7 data ack", a, 1);
    wr(1, 8'h82); send_byte(8'h33, a); chk("R7 data nack", a, 0);
    do_stop; wt(4); chk("R2 busy after stop", bus_busy, 0); chk("R6 hit cleared", addr_hit, 0);

    wr(1, 8'h80);
    do_start; send_byte(8'hA2, a); chk("R4 mismatch nack", a, 0); chk("R4 no hit", addr_hit, 0);
    send_byte(8'hA0, a); chk("R4 later byte ignored", a, 0); do_stop;

    do_start; send_byte(8'hA1, a); chk("R6 read ack", a, 1); chk("R6 rw read", rw_bit, 1);
    send_byte(8'h00, a); chk("R7 no ack after read", a, 0); do_stop;

    wr(0, 8'h70); wr(1, 8'h81);
    do_start; send_byte(8'h7E, a); chk("R5 upper nibble match", a, 1); do_stop;
    do_start; send_byte(8'h00, a); chk("R5 general call", a, 1); do_stop;
    do_start; send_byte(8'h30, a); chk("R5 nibble mismatch", a, 0); do_stop;
    wr(1, 8'h80);
    do_start; send_byte(8'h7E, a); chk("R3 exact mismatch", a, 0); do_stop;

    wr(0, 8'hA0);
    do_start; send_bit(1); send_bit(0); send_bit(1);
    do_start; send_byte(8'hA0, a); chk("R9 restart after repeated start", a, 1); do_stop;

    wr(1, 8'h83);
    do_start;
    for (int i = 7; i >= 0; i--) send_bit(i == 5 || i == 7);
    wt(1); chk("R3 ack driven", sda_oe, 1);
    wr(1, 8'h03); wt(1);
    chk("R8 oe released", sda_oe, 0); chk("R8 busy cleared", bus_busy, 0);
    chk("R8 hit cleared", addr_hit, 0);
    reg_sel = 1; wt(1); chk("R8 ctrl kept", reg_rdata, 8'h03);
    reg_sel = 0; wt(1); chk("R8 addr kept", reg_rdata, 8'hA0);
    m_scl = 1; wt(6); do_stop; wt(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule